// File: doc/BRIEF.md
# Dataflow Dependency Tracker

This block links producers to consumers while an instruction trace streams through it, so that a downstream stage can merge chains of dependent operations into one combined function. It keeps two tables. The register map has one slot per architectural register and points to the graph slot that last wrote that register. The graph table grows by one slot for each accepted operation. Each slot holds a function handle and a flag that marks whether the slot's result is still visible outside the merged graph.

Each incoming operation carries a class, up to two source registers, an optional destination and a function handle. The block resolves both sources against the register map, decides whether the operation joins the graph, updates the consumption and escape state of the source producers, and re-points or invalidates the destination's register-map slot. One cycle later it reports the result of the lookup and of the allocation. Query ports show the slot state and the register map at any time. A trace starts at reset and ends when the graph table is full.

Top module: `dft_tracker`

## Requirements
- R1: After reset the graph count is 0, `gt_full` is 0, every register-map slot reads as no producer (`pq_hit`=0), every graph slot reads as invalid, and `rsp_valid` is 0.
- R2: For each source whose use bit is set, `rsp_sN_hit` reports whether the register had a producer just before the operation was accepted, and `rsp_sN_idx` reports that producer's graph index. A source whose use bit is clear reports no hit.
- R3: A mergeable operation (`in_cls`=00) accepted while not full takes the graph slot whose index equals the current count. It stores `in_func`, sets its output flag and increments the count. If `in_wr` is set, the destination's register-map slot then points to it. With `in_wr` clear (a branch), the register map is unchanged.
- R4: When an operation writes a register whose current producer has been read by an allocated operation and has never been read by a non-allocated one, that producer's output flag is cleared. This includes an operation that reads and writes the same register.
- R5: When a register is overwritten and its producer was never read, the producer keeps its output flag set.
- R6: A load (`in_cls`=01) accepted while not full takes a graph slot like R3, and its sources count as reads inside the graph. Its destination's register-map slot becomes empty, so dependents of the load see a fresh graph input.
- R7: A non-mergeable operation (`in_cls`=10 or 11) takes no slot and leaves the count unchanged. It empties its destination's register-map slot. Its source producers are marked as read outside the graph, so they keep their output flags when later overwritten.
- R8: `gt_full` is 1 exactly when the count equals the table depth. While full, every operation is handled as in R7 until reset.
- R9: `rsp_valid` is 1 in the cycle after an operation is presented and 0 otherwise. `rsp_alloc` tells whether a slot was taken, and `rsp_idx` gives its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, starts a new trace |
| in_valid | input | 1 | An operation is presented this cycle |
| in_cls | input | 2 | Class: 00 mergeable, 01 load, 1x non-mergeable |
| in_s0_use | input | 1 | Source 0 is read |
| in_s0 | input | RW | Source 0 register |
| in_s1_use | input | 1 | Source 1 is read |
| in_s1 | input | RW | Source 1 register |
| in_wr | input | 1 | The operation writes a destination |
| in_dst | input | RW | Destination register |
| in_func | input | FW | Function handle stored in the new slot |
| rsp_valid | output | 1 | Response for the previous cycle's operation |
| rsp_alloc | output | 1 | A graph slot was taken |
| rsp_idx | output | IW | Index of the slot taken |
| rsp_s0_hit | output | 1 | Source 0 had a producer |
| rsp_s0_idx | output | IW | Producer slot of source 0 |
| rsp_s1_hit | output | 1 | Source 1 had a producer |
| rsp_s1_idx | output | IW | Producer slot of source 1 |
| gt_count | output | CW | Number of graph slots in use |
| gt_full | output | 1 | Graph table full |
| gq_idx | input | IW | Graph slot to inspect |
| gq_valid | output | 1 | Inspected slot is in use |
| gq_out | output | 1 | Output flag of inspected slot |
| gq_func | output | FW | Function handle of inspected slot |
| pq_reg | input | RW | Register to inspect |
| pq_hit | output | 1 | Register has a producer slot |
| pq_idx | output | IW | That producer's slot index |

## Verification
Directed chains where each operation reads the previous one's result separate a correct producer lookup from a stale or off-by-one index. An operation that reads and writes the same register, and overwrites of registers that were never read, show whether the flag is cleared only for values that are both read inside the graph and dead. Loads and non-mergeable operations that feed later consumers separate a fresh input from a linked one and an internal read from an external one. Seeded mixed traces on a small table run it to full several times, with resets in between, and after every operation compare every slot and every register-map entry with an arithmetic model.

// File: rtl/dft_pkg.sv
package dft_pkg;
    typedef enum logic [1:0] {
        CLS_MERGE = 2'b00,
        CLS_LOAD  = 2'b01,
        CLS_STOPA = 2'b10,
        CLS_STOPB = 2'b11
    } op_cls_e;

    function automatic logic cls_takes_slot(input logic [1:0] c);
        return (c == CLS_MERGE) || (c == CLS_LOAD);
    endfunction
endpackage

// File: rtl/dft_prod_table.sv
module dft_prod_table #(
    parameter int NREG  = 32,
    parameter int DEPTH = 32,
    parameter int NRD   = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NRD-1:0][$clog2(NREG)-1:0]   rd_reg,
    output logic [NRD-1:0]                     rd_hit,
    output logic [NRD-1:0][$clog2(DEPTH)-1:0]  rd_idx,
    input  logic [$clog2(NREG)-1:0]            q_reg,
    output logic                               q_hit,
    output logic [$clog2(DEPTH)-1:0]           q_idx,
    input  logic                               wr_en,
    input  logic [$clog2(NREG)-1:0]            wr_reg,
    input  logic                               wr_set,
    input  logic [$clog2(DEPTH)-1:0]           wr_idx
);
    localparam int IW = $clog2(DEPTH);

    typedef struct packed {
        logic [NREG-1:0]         vld;
        logic [NREG-1:0][IW-1:0] ptr;
    } map_t;

    map_t st_d, st_q;

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_hit[g] = st_q.vld[rd_reg[g]];
        assign rd_idx[g] = st_q.ptr[rd_reg[g]];
    end

    assign q_hit = st_q.vld[q_reg];
    assign q_idx = st_q.ptr[q_reg];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.vld[wr_reg] = wr_set;
            if (wr_set) begin
                st_d.ptr[wr_reg] = wr_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6/R7: an invalidating write leaves the register without a producer
    a_r7_map_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_set) |=> !st_q.vld[$past(wr_reg)]);
endmodule

// File: rtl/dft_graph_table.sv
module dft_graph_table #(
    parameter int DEPTH = 32,
    parameter int FW    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              alloc_en,
    input  logic [FW-1:0]                     alloc_func,
    input  logic [1:0]                        mk_en,
    input  logic [1:0][$clog2(DEPTH)-1:0]     mk_idx,
    input  logic [1:0]                        mk_ext,
    input  logic                              kill_en,
    input  logic [$clog2(DEPTH)-1:0]          kill_idx,
    output logic [$clog2(DEPTH+1)-1:0]        count,
    output logic                              full,
    input  logic [$clog2(DEPTH)-1:0]          q_idx,
    output logic                              q_vld,
    output logic                              q_out,
    output logic [FW-1:0]                     q_func
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0]         outf;
        logic [DEPTH-1:0]         cons;
        logic [DEPTH-1:0]         ext;
        logic [DEPTH-1:0][FW-1:0] func;
        logic [CW-1:0]            cnt;
    } gt_t;

    gt_t st_d, st_q;
    logic [IW-1:0] slot;
    logic          take;

    assign full   = (st_q.cnt == CW'(DEPTH));
    assign count  = st_q.cnt;
    assign slot   = st_q.cnt[IW-1:0];
    assign take   = alloc_en && !full;
    assign q_vld  = st_q.vld[q_idx];
    assign q_out  = st_q.outf[q_idx];
    assign q_func = st_q.func[q_idx];

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < 2; k++) begin
            if (mk_en[k]) begin
                if (mk_ext[k]) begin
                    st_d.ext[mk_idx[k]] = 1'b1;
                end else begin
                    st_d.cons[mk_idx[k]] = 1'b1;
                end
            end
        end
        if (kill_en && st_d.cons[kill_idx] && !st_d.ext[kill_idx]) begin
            st_d.outf[kill_idx] = 1'b0;
        end
        if (take) begin
            st_d.vld[slot]  = 1'b1;
            st_d.outf[slot] = 1'b1;
            st_d.cons[slot] = 1'b0;
            st_d.ext[slot]  = 1'b0;
            st_d.func[slot] = alloc_func;
            st_d.cnt        = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (full && $stable(st_q.cnt)));
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (st_q.cnt == $past(st_q.cnt) + CW'(1)));
    a_r3_new_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (st_q.vld[$past(slot)] && st_q.outf[$past(slot)]));
    a_r7_ext_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_en && st_q.ext[kill_idx] && st_q.outf[kill_idx]) |=> st_q.outf[$past(kill_idx)]);
endmodule

// File: rtl/dft_tracker.sv
module dft_tracker #(
    parameter int NREG  = 32,
    parameter int DEPTH = 32,
    parameter int FW    = 8,
    localparam int RW   = $clog2(NREG),
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    in_cls,
    input  logic          in_s0_use,
    input  logic [RW-1:0] in_s0,
    input  logic          in_s1_use,
    input  logic [RW-1:0] in_s1,
    input  logic          in_wr,
    input  logic [RW-1:0] in_dst,
    input  logic [FW-1:0] in_func,
    output logic          rsp_valid,
    output logic          rsp_alloc,
    output logic [IW-1:0] rsp_idx,
    output logic          rsp_s0_hit,
    output logic [IW-1:0] rsp_s0_idx,
    output logic          rsp_s1_hit,
    output logic [IW-1:0] rsp_s1_idx,
    output logic [CW-1:0] gt_count,
    output logic          gt_full,
    input  logic [IW-1:0] gq_idx,
    output logic          gq_valid,
    output logic          gq_out,
    output logic [FW-1:0] gq_func,
    input  logic [RW-1:0] pq_reg,
    output logic          pq_hit,
    output logic [IW-1:0] pq_idx
);
    import dft_pkg::*;

    typedef struct packed {
        logic          valid;
        logic          alloc;
        logic [IW-1:0] idx;
        logic [1:0]    hit;
        logic [1:0][IW-1:0] sidx;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [2:0][RW-1:0] rd_reg;
    logic [2:0]         rd_hit;
    logic [2:0][IW-1:0] rd_idx;
    logic [1:0]         use_src;
    logic [1:0]         src_hit;
    logic               alloc;
    logic               stop;
    logic               map_wr, map_set;
    logic [1:0]         mk_en, mk_ext;
    logic               kill_en;
    logic [CW-1:0]      cnt;
    logic               full;

    assign rd_reg  = {in_dst, in_s1, in_s0};
    assign use_src = {in_s1_use, in_s0_use};
    assign gt_count = cnt;
    assign gt_full  = full;

    always_comb begin
        alloc   = in_valid && cls_takes_slot(in_cls) && !full;
        stop    = in_valid && !alloc;
        src_hit = use_src & rd_hit[1:0] & {2{in_valid}};
        mk_en   = src_hit;
        mk_ext  = {2{stop}};
        map_wr  = in_valid && in_wr;
        map_set = alloc && (in_cls == CLS_MERGE);
        kill_en = map_wr && rd_hit[2];

        rsp_d       = '0;
        rsp_d.valid = in_valid;
        rsp_d.alloc = alloc;
        rsp_d.idx   = alloc ? cnt[IW-1:0] : '0;
        rsp_d.hit   = src_hit;
        rsp_d.sidx[0] = src_hit[0] ? rd_idx[0] : '0;
        rsp_d.sidx[1] = src_hit[1] ? rd_idx[1] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_alloc  = rsp_q.alloc;
    assign rsp_idx    = rsp_q.idx;
    assign rsp_s0_hit = rsp_q.hit[0];
    assign rsp_s0_idx = rsp_q.sidx[0];
    assign rsp_s1_hit = rsp_q.hit[1];
    assign rsp_s1_idx = rsp_q.sidx[1];

    dft_prod_table #(.NREG(NREG), .DEPTH(DEPTH), .NRD(3)) map_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_reg (rd_reg),
        .rd_hit (rd_hit),
        .rd_idx (rd_idx),
        .q_reg  (pq_reg),
        .q_hit  (pq_hit),
        .q_idx  (pq_idx),
        .wr_en  (map_wr),
        .wr_reg (in_dst),
        .wr_set (map_set),
        .wr_idx (cnt[IW-1:0])
    );

    dft_graph_table #(.DEPTH(DEPTH), .FW(FW)) graph_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc),
        .alloc_func (in_func),
        .mk_en      (mk_en),
        .mk_idx     (rd_idx[1:0]),
        .mk_ext     (mk_ext),
        .kill_en    (kill_en),
        .kill_idx   (rd_idx[2]),
        .count      (cnt),
        .full       (full),
        .q_idx      (gq_idx),
        .q_vld      (gq_valid),
        .q_out      (gq_out),
        .q_func     (gq_func)
    );

    a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> rsp_valid);
    a_r9_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !rsp_valid);
    a_r7_stop_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cls[1]) |=> (rsp_valid && !rsp_alloc));
    a_r2_link_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pq_hit |-> (CW'(pq_idx) < cnt));
    a_r3_idx_is_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_alloc) |-> (CW'(rsp_idx) + CW'(1) == cnt));
endmodule

// File: tb/dft_tracker_tb_top.sv
module dft_tracker_tb_top;
    localparam int NREG  = 8;
    localparam int DEPTH = 8;
    localparam int FW    = 6;
    localparam int RW    = $clog2(NREG);
    localparam int IW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_cls = '0;
    logic          in_s0_use = 1'b0, in_s1_use = 1'b0, in_wr = 1'b0;
    logic [RW-1:0] in_s0 = '0, in_s1 = '0, in_dst = '0;
    logic [FW-1:0] in_func = '0;
    logic          rsp_valid, rsp_alloc, rsp_s0_hit, rsp_s1_hit;
    logic [IW-1:0] rsp_idx, rsp_s0_idx, rsp_s1_idx;
    logic [CW-1:0] gt_count;
    logic          gt_full;
    logic [IW-1:0] gq_idx = '0;
    logic          gq_valid, gq_out;
    logic [FW-1:0] gq_func;
    logic [RW-1:0] pq_reg = '0;
    logic          pq_hit;
    logic [IW-1:0] pq_idx;

    always #10 clk = ~clk;

    dft_tracker #(.NREG(NREG), .DEPTH(DEPTH), .FW(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
        .in_s0_use(in_s0_use), .in_s0(in_s0), .in_s1_use(in_s1_use), .in_s1(in_s1),
        .in_wr(in_wr), .in_dst(in_dst), .in_func(in_func),
        .rsp_valid(rsp_valid), .rsp_alloc(rsp_alloc), .rsp_idx(rsp_idx),
        .rsp_s0_hit(rsp_s0_hit), .rsp_s0_idx(rsp_s0_idx),
        .rsp_s1_hit(rsp_s1_hit), .rsp_s1_idx(rsp_s1_idx),
        .gt_count(gt_count), .gt_full(gt_full),
        .gq_idx(gq_idx), .gq_valid(gq_valid), .gq_out(gq_out), .gq_func(gq_func),
        .pq_reg(pq_reg), .pq_hit(pq_hit), .pq_idx(pq_idx)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    bit pv[NREG];
    int pp[NREG];
    bit gv[DEPTH], go[DEPTH], gc[DEPTH], ge[DEPTH];
    int gf[DEPTH];
    int cnt;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NREG; i++) begin pv[i] = 0; pp[i] = 0; end
        for (int i = 0; i < DEPTH; i++) begin
            gv[i] = 0; go[i] = 0; gc[i] = 0; ge[i] = 0; gf[i] = 0;
        end
        cnt = 0;
    endtask

    task automatic sweep();
        for (int i = 0; i < DEPTH; i++) begin
            gq_idx = IW'(i);
            #1;
            chk("R3", "slot valid", 32'(gq_valid), 32'(gv[i]));
            chk("R4", "output flag", 32'(gq_out), 32'(go[i]));
            if (gv[i]) chk("R3", "slot func", 32'(gq_func), 32'(gf[i]));
        end
        for (int r = 0; r < NREG; r++) begin
            pq_reg = RW'(r);
            #1;
            chk("R6", "map hit", 32'(pq_hit), 32'(pv[r]));
            if (pv[r]) chk("R3", "map idx", 32'(pq_idx), 32'(pp[r]));
        end
        chk("R8", "count", 32'(gt_count), 32'(cnt));
        chk("R8", "full", 32'(gt_full), 32'(cnt == DEPTH));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        sweep();
    endtask

    task automatic step(input int cls, input bit u0, input int s0, input bit u1,
                        input int s1, input bit wr, input int dst, input int fn);
        bit h0, h1, al, blk;
        int i0, i1, k;
        h0 = u0 && pv[s0]; i0 = pp[s0];
        h1 = u1 && pv[s1]; i1 = pp[s1];
        al = (cls == 0 || cls == 1) && (cnt < DEPTH);
        blk = !al;
        @(negedge clk);
        in_valid = 1'b1; in_cls = 2'(cls);
        in_s0_use = u0; in_s0 = RW'(s0); in_s1_use = u1; in_s1 = RW'(s1);
        in_wr = wr; in_dst = RW'(dst); in_func = FW'(fn);
        @(posedge clk);
        #5;
        in_valid = 1'b0;
        chk("R9", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(blk ? "R7" : "R3", "rsp_alloc", 32'(rsp_alloc), 32'(al));
        if (al) chk("R9", "rsp_idx", 32'(rsp_idx), 32'(cnt));
        chk("R2", "src0 hit", 32'(rsp_s0_hit), 32'(h0));
        if (h0) chk("R2", "src0 idx", 32'(rsp_s0_idx), 32'(i0));
        chk("R2", "src1 hit", 32'(rsp_s1_hit), 32'(h1));
        if (h1) chk("R2", "src1 idx", 32'(rsp_s1_idx), 32'(i1));
        if (h0) begin if (blk) ge[i0] = 1; else gc[i0] = 1; end
        if (h1) begin if (blk) ge[i1] = 1; else gc[i1] = 1; end
        if (wr && pv[dst]) begin
            k = pp[dst];
            if (gc[k] && !ge[k]) go[k] = 0;
        end
        if (al) begin
            gv[cnt] = 1; go[cnt] = 1; gc[cnt] = 0; ge[cnt] = 0; gf[cnt] = fn;
        end
        if (wr) begin
            if (al && cls == 0) begin pv[dst] = 1; pp[dst] = cnt; end
            else pv[dst] = 0;
        end
        if (al) cnt++;
        sweep();
        @(negedge clk);
        chk("R9", "rsp idle", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R3/R2 chain: r1 <- f, r2 <- r1, r1 <- r2 op r1 (R4 same-register case)
        step(0, 0, 0, 0, 0, 1, 1, 5);
        step(0, 1, 1, 0, 0, 1, 2, 7);
        step(0, 1, 2, 1, 1, 1, 1, 9);
        // R5: r3 written, then overwritten without being read
        step(0, 0, 0, 0, 0, 1, 3, 11);
        step(0, 0, 0, 0, 0, 1, 3, 12);
        // branch: reads, no destination
        step(0, 1, 3, 1, 1, 0, 0, 13);
        // R6 load reads r2, writes r4; r4 consumer sees fresh input
        step(1, 1, 2, 0, 0, 1, 4, 20);
        step(0, 1, 4, 0, 0, 1, 5, 21);
        // R7 stop reads r5, then r5 overwritten: flag kept
        step(2, 1, 5, 0, 0, 1, 6, 0);
        step(0, 1, 6, 0, 0, 1, 5, 22);
        // R8: overflow the table
        step(3, 0, 0, 0, 0, 1, 7, 0);
        step(0, 1, 5, 1, 3, 1, 2, 23);
        step(0, 1, 1, 0, 0, 1, 1, 24);
        step(0, 1, 2, 0, 0, 1, 6, 25);
        step(1, 1, 1, 0, 0, 1, 0, 26);
        for (int run = 0; run < 6; run++) begin
            do_reset();
            for (int n = 0; n < 14; n++) begin
                int c, r;
                r = int'($urandom_range(0, 9));
                c = (r < 6) ? 0 : (r < 8) ? 1 : (r == 8) ? 2 : 3;
                step(c, 1'($urandom_range(0, 1)), int'($urandom_range(0, NREG - 1)),
                     1'($urandom_range(0, 1)), int'($urandom_range(0, NREG - 1)),
                     1'($urandom_range(0, 3) != 0), int'($urandom_range(0, NREG - 1)),
                     int'($urandom_range(0, (1 << FW) - 1)));
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule